// File: doc/BRIEF.md
# Register-Based Fast System Call Transition Unit

This block performs the privilege switch of a 64-bit core when software uses the fast, register-based system-call path. On a call request, the return address and the current flags go to two general registers through write-back ports. The kernel code and stack selectors are derived from one selector configuration word. The flags are masked, and the program counter jumps to a configured kernel entry address. On a return request, the unit restores user state from the two saved registers. The return is allowed only when the core is at privilege level 0.

The unit owns a registered copy of the architectural PC, flags, code and stack selectors and privilege level. These change only at the clock edge that accepts a request. A one-cycle pulse reports completion, a protection fault or an illegal request. The stack pointer is deliberately absent: kernel software must load a safe stack itself.

Top module: `fastcall_unit`

## Requirements
- R1: After reset, the PC, flags, both selectors and write-back data read 0, `priv_q` reads 3, and `done`, `gp_fault`, `illegal`, `wb_ret_en` and `wb_flg_en` are all low.
- R2: A call request (`call_req`=1, `ret_req`=0), sampled at a clock edge, makes `wb_ret_data` equal `cur_pc`+2 (modulo 2^64) and `wb_flg_data` equal `cur_flags` after that edge. `wb_ret_en` and `wb_flg_en` are high for exactly that one cycle.
- R3: After a call, `code_sel` equals bits 47:32 of `sel_cfg`, and `stack_sel` equals that value plus 8, modulo 2^16.
- R4: After a call, `flags_q` equals `cur_flags` AND NOT `flag_mask`.
- R5: After a call, `pc_q` equals `entry_cfg` and `priv_q` equals 0, with `done` high for one cycle. This holds at any incoming privilege level.
- R6: A return request with `cur_priv` not equal to 0 pulses `gp_fault` for one cycle. It changes none of the PC, flags, selector or privilege outputs, and it asserts neither write enable nor `done`.
- R7: A return request with `cur_priv`=0 sets `code_sel` to bits 63:48 of `sel_cfg` plus 16 and `stack_sel` to the same bits plus 8, both modulo 2^16. It also sets `pc_q` to `ret_addr_in`, `flags_q` to `saved_flags_in` and `priv_q` to 3, and pulses `done`.
- R8: When `call_req` and `ret_req` are both high at an edge, `illegal` pulses for one cycle. No state output changes, and neither write enable nor `done` rises.
- R9: In a cycle with no request, all pulses and write enables are low and the state outputs keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| call_req | input | 1 | Request a call transition |
| ret_req | input | 1 | Request a return transition |
| cur_pc | input | 64 | Address of the call instruction |
| cur_flags | input | 64 | Current flags word |
| cur_priv | input | 2 | Current privilege level |
| sel_cfg | input | 64 | Selector configuration word |
| entry_cfg | input | 64 | Kernel entry address |
| flag_mask | input | 64 | Flag bits to clear on a call |
| ret_addr_in | input | 64 | Contents of the return-address register |
| saved_flags_in | input | 64 | Contents of the saved-flags register |
| pc_q | output | 64 | PC after the last transition |
| flags_q | output | 64 | Flags after the last transition |
| code_sel | output | 16 | Code selector |
| stack_sel | output | 16 | Stack selector |
| priv_q | output | 2 | Privilege level |
| wb_ret_en | output | 1 | Write strobe for the return-address register |
| wb_ret_data | output | 64 | Value for the return-address register |
| wb_flg_en | output | 1 | Write strobe for the saved-flags register |
| wb_flg_data | output | 64 | Value for the saved-flags register |
| done | output | 1 | Transition completed |
| gp_fault | output | 1 | Return refused at nonzero privilege |
| illegal | output | 1 | Both requests asserted together |

## Verification
Random calls use arbitrary PCs, flag words and masks. Comparing the masked flags against the saved flags separates the clearing path from the save path. Returns are issued at privilege 0, 1 and 3, so the fault path and the restore path each run with state that differs from the previous transition. Directed cases cover a PC of all ones, where the +2 must wrap, and selector fields near 0xFFFF, which expose carries that leak past 16 bits. They also cover simultaneous call and return requests and idle gaps between requests, which show whether pulses stay one cycle long and whether state is held.

// File: rtl/fc_pkg.sv
package fc_pkg;
   parameter int XLEN = 64;
   parameter int SELW = 16;
   parameter int PRVW = 2;

   typedef struct packed {
      logic [XLEN-1:0] pc;
      logic [XLEN-1:0] flags;
      logic [SELW-1:0] csel;
      logic [SELW-1:0] ssel;
      logic [PRVW-1:0] priv;
   } arch_state_t;
endpackage

// File: rtl/fc_req_decode.sv
module fc_req_decode #(
   parameter int PRVW = fc_pkg::PRVW
) (
   input  logic            call_req,
   input  logic            ret_req,
   input  logic [PRVW-1:0] cur_priv,
   output logic            go_call,
   output logic            go_ret,
   output logic            go_fault,
   output logic            go_ill
);
   logic priv_is_kernel;

   always_comb begin
      priv_is_kernel = (cur_priv == '0);
      go_ill   = call_req & ret_req;
      go_call  = call_req & ~ret_req;
      go_ret   = ret_req & ~call_req & priv_is_kernel;
      go_fault = ret_req & ~call_req & ~priv_is_kernel;
   end
endmodule

// File: rtl/fc_entry_path.sv
module fc_entry_path
   import fc_pkg::*;
#(
   parameter int ILEN     = 2,
   parameter int KSEL_LSB = 32,
   parameter int KSTK_OFS = 8
) (
   input  logic [XLEN-1:0] cur_pc,
   input  logic [XLEN-1:0] cur_flags,
   input  logic [XLEN-1:0] sel_cfg,
   input  logic [XLEN-1:0] entry_cfg,
   input  logic [XLEN-1:0] flag_mask,
   output arch_state_t     nxt,
   output logic [XLEN-1:0] ret_addr,
   output logic [XLEN-1:0] save_flags
);
   localparam logic [XLEN-1:0] ILEN_V = XLEN'(ILEN);
   localparam logic [SELW-1:0] KOFS_V = SELW'(KSTK_OFS);

   logic [XLEN-1:0] masked;
   logic [SELW-1:0] kcs;

   generate
      for (genvar b = 0; b < XLEN; b++) begin : g_mask
         assign masked[b] = cur_flags[b] & ~flag_mask[b];
      end
   endgenerate

   assign kcs        = sel_cfg[KSEL_LSB +: SELW];
   assign ret_addr   = cur_pc + ILEN_V;
   assign save_flags = cur_flags;

   always_comb begin
      nxt.pc    = entry_cfg;
      nxt.flags = masked;
      nxt.csel  = kcs;
      nxt.ssel  = kcs + KOFS_V;
      nxt.priv  = '0;
   end
endmodule

// File: rtl/fc_return_path.sv
module fc_return_path
   import fc_pkg::*;
#(
   parameter int USEL_LSB = 48,
   parameter int UCS_OFS  = 16,
   parameter int USS_OFS  = 8,
   parameter int USER_PRV = 3
) (
   input  logic [XLEN-1:0] sel_cfg,
   input  logic [XLEN-1:0] ret_addr_in,
   input  logic [XLEN-1:0] saved_flags_in,
   output arch_state_t     nxt
);
   localparam logic [SELW-1:0] UCS_V = SELW'(UCS_OFS);
   localparam logic [SELW-1:0] USS_V = SELW'(USS_OFS);

   logic [SELW-1:0] base;
   assign base = sel_cfg[USEL_LSB +: SELW];

   always_comb begin
      nxt.pc    = ret_addr_in;
      nxt.flags = saved_flags_in;
      nxt.csel  = base + UCS_V;
      nxt.ssel  = base + USS_V;
      nxt.priv  = PRVW'(USER_PRV);
   end
endmodule

// File: rtl/fastcall_unit.sv
module fastcall_unit
   import fc_pkg::*;
#(
   parameter int ILEN     = 2,
   parameter int KSEL_LSB = 32,
   parameter int USEL_LSB = 48,
   parameter int KSTK_OFS = 8,
   parameter int UCS_OFS  = 16,
   parameter int USS_OFS  = 8,
   parameter int USER_PRV = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            call_req,
   input  logic            ret_req,
   input  logic [63:0]     cur_pc,
   input  logic [63:0]     cur_flags,
   input  logic [1:0]      cur_priv,
   input  logic [63:0]     sel_cfg,
   input  logic [63:0]     entry_cfg,
   input  logic [63:0]     flag_mask,
   input  logic [63:0]     ret_addr_in,
   input  logic [63:0]     saved_flags_in,
   output logic [63:0]     pc_q,
   output logic [63:0]     flags_q,
   output logic [15:0]     code_sel,
   output logic [15:0]     stack_sel,
   output logic [1:0]      priv_q,
   output logic            wb_ret_en,
   output logic [63:0]     wb_ret_data,
   output logic            wb_flg_en,
   output logic [63:0]     wb_flg_data,
   output logic            done,
   output logic            gp_fault,
   output logic            illegal
);
   generate
      if (XLEN != 64 || SELW != 16 || PRVW != 2) begin : g_bad_pkg
         $error("fastcall_unit: package widths do not match port widths");
      end
      if (KSEL_LSB + SELW > XLEN || USEL_LSB + SELW > XLEN) begin : g_bad_field
         $error("fastcall_unit: selector field outside config word");
      end
      if (ILEN < 1 || USER_PRV < 1 || USER_PRV >= (1 << PRVW)) begin : g_bad_opt
         $error("fastcall_unit: bad instruction length or user level");
      end
   endgenerate

   logic go_call, go_ret, go_fault, go_ill;
   arch_state_t ent_nxt, ret_nxt, st_q;
   logic [XLEN-1:0] ent_ra, ent_fl;

   fc_req_decode #(.PRVW(PRVW)) u_dec (
      .call_req (call_req),
      .ret_req  (ret_req),
      .cur_priv (cur_priv),
      .go_call  (go_call),
      .go_ret   (go_ret),
      .go_fault (go_fault),
      .go_ill   (go_ill)
   );

   fc_entry_path #(
      .ILEN(ILEN), .KSEL_LSB(KSEL_LSB), .KSTK_OFS(KSTK_OFS)
   ) u_ent (
      .cur_pc     (cur_pc),
      .cur_flags  (cur_flags),
      .sel_cfg    (sel_cfg),
      .entry_cfg  (entry_cfg),
      .flag_mask  (flag_mask),
      .nxt        (ent_nxt),
      .ret_addr   (ent_ra),
      .save_flags (ent_fl)
   );

   fc_return_path #(
      .USEL_LSB(USEL_LSB), .UCS_OFS(UCS_OFS), .USS_OFS(USS_OFS), .USER_PRV(USER_PRV)
   ) u_ret (
      .sel_cfg        (sel_cfg),
      .ret_addr_in    (ret_addr_in),
      .saved_flags_in (saved_flags_in),
      .nxt            (ret_nxt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q        <= '{pc: '0, flags: '0, csel: '0, ssel: '0, priv: PRVW'(USER_PRV)};
         wb_ret_en   <= 1'b0;
         wb_flg_en   <= 1'b0;
         wb_ret_data <= '0;
         wb_flg_data <= '0;
         done        <= 1'b0;
         gp_fault    <= 1'b0;
         illegal     <= 1'b0;
      end else begin
         done      <= go_call | go_ret;
         gp_fault  <= go_fault;
         illegal   <= go_ill;
         wb_ret_en <= go_call;
         wb_flg_en <= go_call;
         if (go_call) begin
            st_q        <= ent_nxt;
            wb_ret_data <= ent_ra;
            wb_flg_data <= ent_fl;
         end else if (go_ret) begin
            st_q <= ret_nxt;
         end
      end
   end

   assign pc_q      = st_q.pc;
   assign flags_q   = st_q.flags;
   assign code_sel  = st_q.csel;
   assign stack_sel = st_q.ssel;
   assign priv_q    = st_q.priv;
endmodule

// File: rtl/fastcall_unit_chk.sv
module fastcall_unit_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        call_req,
   input logic        ret_req,
   input logic [63:0] cur_pc,
   input logic [1:0]  cur_priv,
   input logic [63:0] entry_cfg,
   input logic [63:0] pc_q,
   input logic [15:0] code_sel,
   input logic [15:0] stack_sel,
   input logic [1:0]  priv_q,
   input logic        wb_ret_en,
   input logic [63:0] wb_ret_data,
   input logic        done,
   input logic        gp_fault,
   input logic        illegal
);
   // R9
   pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({done, gp_fault, illegal}));

   // R5
   call_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (call_req && !ret_req) |=> (done && priv_q == 2'd0 && pc_q == $past(entry_cfg)));

   // R2
   call_ra_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (call_req && !ret_req) |=> (wb_ret_en && wb_ret_data == $past(cur_pc) + 64'd2));

   // R3
   kstack_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (call_req && !ret_req) |=> (stack_sel == code_sel + 16'd8));

   // R6
   ret_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_req && !call_req && cur_priv != 2'd0) |=>
         (gp_fault && !done && !wb_ret_en && $stable(pc_q) && $stable(priv_q)));

   // R8
   both_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (call_req && ret_req) |=> (illegal && !done && $stable(pc_q) && $stable(code_sel)));
endmodule

bind fastcall_unit fastcall_unit_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .call_req    (call_req),
   .ret_req     (ret_req),
   .cur_pc      (cur_pc),
   .cur_priv    (cur_priv),
   .entry_cfg   (entry_cfg),
   .pc_q        (pc_q),
   .code_sel    (code_sel),
   .stack_sel   (stack_sel),
   .priv_q      (priv_q),
   .wb_ret_en   (wb_ret_en),
   .wb_ret_data (wb_ret_data),
   .done        (done),
   .gp_fault    (gp_fault),
   .illegal     (illegal)
);

// File: tb/tb_fastcall_unit.sv
module tb_fastcall_unit;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic call_req = 1'b0, ret_req = 1'b0;
   logic [63:0] cur_pc = '0, cur_flags = '0, sel_cfg = '0, entry_cfg = '0, flag_mask = '0;
   logic [63:0] ret_addr_in = '0, saved_flags_in = '0;
   logic [1:0]  cur_priv = '0;
   logic [63:0] pc_q, flags_q, wb_ret_data, wb_flg_data;
   logic [15:0] code_sel, stack_sel;
   logic [1:0]  priv_q;
   logic wb_ret_en, wb_flg_en, done, gp_fault, illegal;

   int vectors = 0, fails = 0, cycles = 0;
   bit finished = 0;

   logic [63:0] m_pc, m_fl, m_wr, m_wf;
   logic [15:0] m_cs, m_ss;
   logic [1:0]  m_pr;
   logic m_wre, m_wfe, m_done, m_gpf, m_ill;

   always #2 clk = ~clk;

   fastcall_unit dut (
      .clk(clk), .rst_n(rst_n), .call_req(call_req), .ret_req(ret_req),
      .cur_pc(cur_pc), .cur_flags(cur_flags), .cur_priv(cur_priv),
      .sel_cfg(sel_cfg), .entry_cfg(entry_cfg), .flag_mask(flag_mask),
      .ret_addr_in(ret_addr_in), .saved_flags_in(saved_flags_in),
      .pc_q(pc_q), .flags_q(flags_q), .code_sel(code_sel), .stack_sel(stack_sel),
      .priv_q(priv_q), .wb_ret_en(wb_ret_en), .wb_ret_data(wb_ret_data),
      .wb_flg_en(wb_flg_en), .wb_flg_data(wb_flg_data), .done(done),
      .gp_fault(gp_fault), .illegal(illegal)
   );

   function automatic logic [15:0] kcs_of(logic [63:0] c); return c[47:32]; endfunction
   function automatic logic [15:0] ucs_of(logic [63:0] c); return c[63:48] + 16'd16; endfunction
   function automatic logic [15:0] uss_of(logic [63:0] c); return c[63:48] + 16'd8; endfunction

   task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic check_all(string tag);
      chk(tag, "pc", pc_q, m_pc);
      chk(tag, "flags", flags_q, m_fl);
      chk(tag, "code_sel", 64'(code_sel), 64'(m_cs));
      chk(tag, "stack_sel", 64'(stack_sel), 64'(m_ss));
      chk(tag, "priv", 64'(priv_q), 64'(m_pr));
      chk(tag, "done", 64'(done), 64'(m_done));
      chk(tag, "gp_fault", 64'(gp_fault), 64'(m_gpf));
      chk(tag, "illegal", 64'(illegal), 64'(m_ill));
      chk(tag, "wb_ret_en", 64'(wb_ret_en), 64'(m_wre));
      chk(tag, "wb_flg_en", 64'(wb_flg_en), 64'(m_wfe));
      if (m_wre) chk(tag, "wb_ret_data", wb_ret_data, m_wr);
      if (m_wfe) chk(tag, "wb_flg_data", wb_flg_data, m_wf);
   endtask

   // Drive one request at a negedge, update model, sample next negedge, then an idle cycle.
   task automatic apply(bit c, bit r, string tag);
      call_req = c; ret_req = r;
      m_done = 0; m_gpf = 0; m_ill = 0; m_wre = 0; m_wfe = 0;
      if (c && r) m_ill = 1;                              // R8
      else if (c) begin                                    // R2 R3 R4 R5
         m_wr = cur_pc + 64'd2; m_wf = cur_flags; m_wre = 1; m_wfe = 1;
         m_pc = entry_cfg; m_fl = cur_flags & ~flag_mask;
         m_cs = kcs_of(sel_cfg); m_ss = kcs_of(sel_cfg) + 16'd8;
         m_pr = 2'd0; m_done = 1;
      end else if (r && cur_priv != 2'd0) m_gpf = 1;      // R6
      else if (r) begin                                    // R7
         m_pc = ret_addr_in; m_fl = saved_flags_in;
         m_cs = ucs_of(sel_cfg); m_ss = uss_of(sel_cfg);
         m_pr = 2'd3; m_done = 1;
      end
      @(negedge clk);
      check_all(tag);
      call_req = 0; ret_req = 0;
      m_done = 0; m_gpf = 0; m_ill = 0; m_wre = 0; m_wfe = 0;
      // idle cycle with inputs scrambled: state must hold (R9)
      cur_pc = {$urandom, $urandom}; sel_cfg = {$urandom, $urandom};
      @(negedge clk);
      check_all("R9");
   endtask

   task automatic rand_inputs();
      cur_pc = {$urandom, $urandom}; cur_flags = {$urandom, $urandom};
      sel_cfg = {$urandom, $urandom}; entry_cfg = {$urandom, $urandom};
      flag_mask = {$urandom, $urandom}; ret_addr_in = {$urandom, $urandom};
      saved_flags_in = {$urandom, $urandom};
   endtask

   initial begin
      void'($urandom(32'd1234));
      m_pc = '0; m_fl = '0; m_cs = '0; m_ss = '0; m_pr = 2'd3;
      m_wr = '0; m_wf = '0; m_wre = 0; m_wfe = 0; m_done = 0; m_gpf = 0; m_ill = 0;
      repeat (3) @(negedge clk);
      check_all("R1");
      chk("R1", "wb_ret_data", wb_ret_data, 64'd0);
      chk("R1", "wb_flg_data", wb_flg_data, 64'd0);
      rst_n = 1;
      @(negedge clk);
      check_all("R9");

      // directed: call with PC wrap and selector carry
      rand_inputs(); cur_pc = '1; sel_cfg = 64'h0000_FFFC_0000_0000; cur_priv = 2'd3;
      apply(1, 0, "R2");
      // directed: return with user selector carry
      rand_inputs(); sel_cfg = 64'hFFF8_0000_0000_0000; cur_priv = 2'd0;
      apply(0, 1, "R7");
      // directed: return refused at privilege 3 and 1
      rand_inputs(); cur_priv = 2'd3; apply(0, 1, "R6");
      rand_inputs(); cur_priv = 2'd1; apply(0, 1, "R6");
      // directed: both requests
      rand_inputs(); cur_priv = 2'd0; apply(1, 1, "R8");
      // directed: mask clearing all flags
      rand_inputs(); flag_mask = '1; cur_priv = 2'd3; apply(1, 0, "R4");
      // call from privilege 0 still enters
      rand_inputs(); cur_priv = 2'd0; apply(1, 0, "R5");

      for (int i = 0; i < 400; i++) begin
         int k;
         rand_inputs();
         k = $urandom_range(0, 9);
         cur_priv = 2'($urandom_range(0, 3));
         if (k < 4) apply(1, 0, "R3");
         else if (k < 8) apply(0, 1, (cur_priv == 0) ? "R7" : "R6");
         else if (k == 8) apply(1, 1, "R8");
         else apply(0, 0, "R9");
      end
      finished = 1;
   end

   initial begin
      while (!finished && cycles < 20000) begin
         @(posedge clk);
         cycles++;
      end
      if (!finished) begin
         fails++;
         $display("FAIL watchdog expired actual=%0d expected=<20000", cycles);
      end
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule